// File: doc/BRIEF.md
# Multilevel Wavelet Input Block Scheduler

This block cuts a row-major image into rectangular tiles for a parallel wavelet engine. The engine computes every decomposition level of a 2-D transform at the same time and keeps no frame buffer. One tile descriptor goes out per cycle. It carries the tile's top-left row and column, its height and width, and a flat address for each lane. The lanes are numbered row-major inside the tile, so the processing units downstream receive tiles with no gaps between them and no overlap.

The tile shape comes from two settings: the number of levels L and a scaling exponent E. One side of the tile is 2^(L+E) samples long and the other is 2^(L-1). The lane count is the product of the two. E = 0 gives the smallest tile that L levels allow. In wide mode the long side runs along a row. In tall mode it runs down a column. L, E and the mode are captured on a start pulse. The scheduler then walks the frame until the last tile is accepted. Tiles go left to right across a band whose height is the tile height, and the bands go from the top of the image to the bottom.

The descriptor output is valid/ready:
- `blk_valid` never waits for `blk_ready`.
- While `blk_valid` is high and `blk_ready` is low, every descriptor output holds its value.
- A tile counts as transferred on a clock edge where both signals are high.
- With `blk_ready` held high, a new tile is sent on every cycle.

Top module: `wvl_blk_sched`

## Requirements
- R1: After reset, `blk_valid`, `busy` and `cfg_err` are all 0.
- R2: With `cfg_tall`=0, each tile has height 2^(L-1) and width 2^(L+E), where L is `cfg_levels` and E is `cfg_scale`.
- R3: With `cfg_tall`=1, each tile has height 2^(L+E) and width 2^(L-1).
- R4: The first tile is at row 0, column 0. Each accepted tile moves the column on by the tile width. After the tile that touches the right edge, the column returns to 0 and the row moves on by the tile height. Every pixel is covered exactly once per frame.
- R5: Lane k is enabled when k < height·width. Lane k sits at in-tile row i = k / width and column j = k mod width. Its address is (blk_row + i)·IMG_W + blk_col + j, packed at bits [k·AW +: AW] of `lane_addr`. A disabled lane has address 0.
- R6: While `blk_valid` is high and `blk_ready` is low, the descriptor holds its value. With `blk_ready` held high, a frame of n tiles stays busy for exactly n cycles.
- R7: `blk_last` is high only on the final tile of a frame. After that tile is accepted, `blk_valid` and `busy` drop on the next cycle.
- R8: A start pulse seen while idle with a legal setting makes `blk_valid` high on the next cycle.
- R9: A start with L = 0, L > MAX_J, E > MAX_R, or image sides that are not multiples of the tile sides sets `cfg_err` on the next cycle and issues no tile. The next start with a legal setting clears `cfg_err`.
- R10: While `busy` is high, changes on `cfg_*` and pulses on `start` have no effect on the tiles issued. This holds in the cycle where the final tile is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start pulse, sampled while idle |
| cfg_levels | input | JW | Number of decomposition levels L |
| cfg_scale | input | RW | Scaling exponent E |
| cfg_tall | input | 1 | 0 = wide tile, 1 = tall tile |
| blk_ready | input | 1 | Consumer accepts the descriptor |
| blk_valid | output | 1 | Descriptor valid |
| blk_row | output | DW | Top row of the tile |
| blk_col | output | DW | Left column of the tile |
| blk_h | output | DW | Tile height |
| blk_w | output | DW | Tile width |
| blk_last | output | 1 | Final tile of the frame |
| lane_en | output | NL | Enable for each lane |
| lane_addr | output | NL·AW | Flat address for each lane |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start had an illegal setting |

## Verification
Two events can land on the same clock edge: the acceptance of the final tile and a new start pulse. The scheduler must finish the frame and must not begin a second one. The bench provokes this by raising `start`, with a different shape on `cfg_*`, in exactly the cycle where `blk_last`, `blk_valid` and `blk_ready` are all high. One cycle later it expects `busy` and `blk_valid` low, and no unexpected tile reaching the scoreboard. It also pulses `start` and changes the settings in the middle of a frame under irregular back-pressure. Every tile must still match the queue built from the settings captured at frame start.

// File: rtl/wvl_pkg.sv
package wvl_pkg;
  typedef enum logic {TILE_WIDE = 1'b0, TILE_TALL = 1'b1} tile_mode_e;
endpackage

// File: rtl/wvl_shape.sv
module wvl_shape #(
  parameter int IMG_W = 24,
  parameter int IMG_H = 16,
  parameter int MAX_J = 2,
  parameter int MAX_R = 2,
  parameter int JW    = 2,
  parameter int RW    = 2,
  parameter int LW    = 4,
  parameter int DW    = 5
) (
  input  logic [JW-1:0] levels,
  input  logic [RW-1:0] scale,
  input  logic          tall,
  output logic [LW-1:0] h_log,
  output logic [LW-1:0] w_log,
  output logic [DW-1:0] h_dim,
  output logic [DW-1:0] w_dim,
  output logic          bad
);
  import wvl_pkg::*;

  logic [LW-1:0] long_l, short_l;

  always_comb begin
    long_l  = LW'(levels) + LW'(scale);
    short_l = LW'(levels) - LW'(1);
    if (tile_mode_e'(tall) == TILE_TALL) begin
      h_log = long_l;
      w_log = short_l;
    end else begin
      h_log = short_l;
      w_log = long_l;
    end
    h_dim = (h_log < LW'(DW)) ? (DW'(1) << h_log) : '0;
    w_dim = (w_log < LW'(DW)) ? (DW'(1) << w_log) : '0;
    bad = (levels == '0) || (int'(levels) > MAX_J) || (int'(scale) > MAX_R) ||
          (h_dim == '0) || (w_dim == '0) ||
          ((DW'(IMG_H) & (h_dim - DW'(1))) != '0) ||
          ((DW'(IMG_W) & (w_dim - DW'(1))) != '0);
  end
endmodule

// File: rtl/wvl_walk.sv
module wvl_walk #(
  parameter int IMG_W = 24,
  parameter int IMG_H = 16,
  parameter int LW    = 4,
  parameter int DW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bad,
  input  logic [LW-1:0] h_log_in,
  input  logic [LW-1:0] w_log_in,
  input  logic [DW-1:0] h_dim_in,
  input  logic [DW-1:0] w_dim_in,
  input  logic          ready,
  output logic          valid,
  output logic          last,
  output logic          err,
  output logic [DW-1:0] row,
  output logic [DW-1:0] col,
  output logic [DW-1:0] h_q,
  output logic [DW-1:0] w_q,
  output logic [LW-1:0] hl_q,
  output logic [LW-1:0] wl_q
);
  logic          busy_q;
  logic [DW:0]   col_nx, row_nx;
  logic          col_end, row_end, take;

  assign col_nx  = {1'b0, col} + {1'b0, w_q};
  assign row_nx  = {1'b0, row} + {1'b0, h_q};
  assign col_end = (col_nx == (DW+1)'(IMG_W));
  assign row_end = (row_nx == (DW+1)'(IMG_H));
  assign last    = col_end && row_end;
  assign valid   = busy_q;
  assign take    = busy_q && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err    <= 1'b0;
      row    <= '0;
      col    <= '0;
      h_q    <= '0;
      w_q    <= '0;
      hl_q   <= '0;
      wl_q   <= '0;
    end else if (!busy_q && start) begin
      err    <= bad;
      busy_q <= !bad;
      row    <= '0;
      col    <= '0;
      h_q    <= h_dim_in;
      w_q    <= w_dim_in;
      hl_q   <= h_log_in;
      wl_q   <= w_log_in;
    end else if (take) begin
      if (last) begin
        busy_q <= 1'b0;
      end else if (col_end) begin
        col <= '0;
        row <= row_nx[DW-1:0];
      end else begin
        col <= col_nx[DW-1:0];
      end
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(row) && $stable(col) && $stable(h_q));
  // R7
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && last |=> !valid);
  // R8
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && start && !bad |=> valid && row == '0 && col == '0);
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && err));
  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(h_q) && $stable(w_q) && $stable(hl_q));
  // R4
  col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((col & (w_q - DW'(1))) == '0) && ((row & (h_q - DW'(1))) == '0));
endmodule

// File: rtl/wvl_lane_addr.sv
module wvl_lane_addr #(
  parameter int IMG_W = 24,
  parameter int NL    = 32,
  parameter int LW    = 4,
  parameter int DW    = 5,
  parameter int AW    = 9
) (
  input  logic [DW-1:0]    row,
  input  logic [DW-1:0]    col,
  input  logic [LW-1:0]    hl,
  input  logic [LW-1:0]    wl,
  output logic [NL-1:0]    en,
  output logic [NL*AW-1:0] addr
);
  localparam int KW = $clog2(NL) + 1;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [KW-1:0] ii, jj;
    logic          on;
    always_comb begin
      ii = KW'(k) >> wl;
      jj = KW'(k) & ~({KW{1'b1}} << wl);
      on = ((KW'(k) >> (hl + wl)) == '0);
    end
    assign en[k] = on;
    assign addr[k*AW +: AW] = on ?
      ((AW'(row) + AW'(ii)) * AW'(IMG_W) + AW'(col) + AW'(jj)) : '0;
  end
endmodule

// File: rtl/wvl_blk_sched.sv
module wvl_blk_sched #(
  parameter int IMG_W = 24,
  parameter int IMG_H = 16,
  parameter int MAX_J = 2,
  parameter int MAX_R = 2,
  localparam int JW = $clog2(MAX_J + 2),
  localparam int RW = $clog2(MAX_R + 2),
  localparam int LW = ((JW > RW) ? JW : RW) + 2,
  localparam int DA = ($clog2(IMG_W + 1) > $clog2(IMG_H + 1)) ? $clog2(IMG_W + 1) : $clog2(IMG_H + 1),
  localparam int DW = (DA > MAX_J + MAX_R + 1) ? DA : (MAX_J + MAX_R + 1),
  localparam int AW = $clog2(IMG_W * IMG_H),
  localparam int NL = 2 ** (2 * MAX_J - 1 + MAX_R)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [JW-1:0]    cfg_levels,
  input  logic [RW-1:0]    cfg_scale,
  input  logic             cfg_tall,
  input  logic             blk_ready,
  output logic             blk_valid,
  output logic [DW-1:0]    blk_row,
  output logic [DW-1:0]    blk_col,
  output logic [DW-1:0]    blk_h,
  output logic [DW-1:0]    blk_w,
  output logic             blk_last,
  output logic [NL-1:0]    lane_en,
  output logic [NL*AW-1:0] lane_addr,
  output logic             busy,
  output logic             cfg_err
);
  logic [LW-1:0] h_log, w_log, hl_q, wl_q;
  logic [DW-1:0] h_dim, w_dim;
  logic          bad;

  wvl_shape #(.IMG_W(IMG_W), .IMG_H(IMG_H), .MAX_J(MAX_J), .MAX_R(MAX_R),
              .JW(JW), .RW(RW), .LW(LW), .DW(DW)) shape_i (
    .levels(cfg_levels), .scale(cfg_scale), .tall(cfg_tall),
    .h_log(h_log), .w_log(w_log), .h_dim(h_dim), .w_dim(w_dim), .bad(bad));

  wvl_walk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .LW(LW), .DW(DW)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bad(bad),
    .h_log_in(h_log), .w_log_in(w_log), .h_dim_in(h_dim), .w_dim_in(w_dim),
    .ready(blk_ready), .valid(blk_valid), .last(blk_last), .err(cfg_err),
    .row(blk_row), .col(blk_col), .h_q(blk_h), .w_q(blk_w),
    .hl_q(hl_q), .wl_q(wl_q));

  wvl_lane_addr #(.IMG_W(IMG_W), .NL(NL), .LW(LW), .DW(DW), .AW(AW)) lane_i (
    .row(blk_row), .col(blk_col), .hl(hl_q), .wl(wl_q),
    .en(lane_en), .addr(lane_addr));

  assign busy = blk_valid;

  // R5
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> $countones(lane_en) == 32'(blk_h) * 32'(blk_w));
  // R5
  lane_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> lane_addr[AW-1:0] == AW'(blk_row) * AW'(IMG_W) + AW'(blk_col));
endmodule

// File: tb/wvl_blk_sched_tb_top.sv
`timescale 1ns/1ps
module wvl_blk_sched_tb_top;
  localparam int IMG_W = 24, IMG_H = 16, MAX_J = 2, MAX_R = 2;
  localparam int JW = $clog2(MAX_J + 2), RW = $clog2(MAX_R + 2);
  localparam int DA = ($clog2(IMG_W + 1) > $clog2(IMG_H + 1)) ? $clog2(IMG_W + 1) : $clog2(IMG_H + 1);
  localparam int DW = (DA > MAX_J + MAX_R + 1) ? DA : (MAX_J + MAX_R + 1);
  localparam int AW = $clog2(IMG_W * IMG_H);
  localparam int NL = 2 ** (2 * MAX_J - 1 + MAX_R);

  logic clk = 0, rst_n = 0, start = 0, cfg_tall = 0, blk_ready = 1;
  logic [JW-1:0] cfg_levels = '0;
  logic [RW-1:0] cfg_scale = '0;
  logic blk_valid, blk_last, busy, cfg_err;
  logic [DW-1:0] blk_row, blk_col, blk_h, blk_w;
  logic [NL-1:0] lane_en;
  logic [NL*AW-1:0] lane_addr;

  wvl_blk_sched #(.IMG_W(IMG_W), .IMG_H(IMG_H), .MAX_J(MAX_J), .MAX_R(MAX_R)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_levels(cfg_levels),
    .cfg_scale(cfg_scale), .cfg_tall(cfg_tall), .blk_ready(blk_ready),
    .blk_valid(blk_valid), .blk_row(blk_row), .blk_col(blk_col), .blk_h(blk_h),
    .blk_w(blk_w), .blk_last(blk_last), .lane_en(lane_en), .lane_addr(lane_addr),
    .busy(busy), .cfg_err(cfg_err));

  always #2 clk = ~clk;

  typedef struct packed { int row; int col; int h; int w; bit last; } item_t;
  item_t expq[$];
  int checks = 0, fails = 0;
  bit bp_on = 0, done = 0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    blk_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit hold_prev = 0;
  int hr, hc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev && blk_valid)  // R6 stability under back-pressure
        chk(int'(blk_row) == hr && int'(blk_col) == hc, "R6", "held row*1000+col",
            int'(blk_row) * 1000 + int'(blk_col), hr * 1000 + hc);
      hold_prev = blk_valid && !blk_ready;
      hr = int'(blk_row); hc = int'(blk_col);
      if (blk_valid && blk_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R4", "unexpected tile row*1000+col", int'(blk_row) * 1000 + int'(blk_col), -1);
        end else begin
          item_t e;
          bit lane_ok;
          int bad_k;
          e = expq.pop_front();
          // R2 R3 R4 R7 descriptor
          chk(int'(blk_row) == e.row && int'(blk_col) == e.col, "R4", "tile row*1000+col",
              int'(blk_row) * 1000 + int'(blk_col), e.row * 1000 + e.col);
          chk(int'(blk_h) == e.h && int'(blk_w) == e.w, "R2_R3", "tile h*100+w",
              int'(blk_h) * 100 + int'(blk_w), e.h * 100 + e.w);
          chk(blk_last == e.last, "R7", "blk_last", int'(blk_last), int'(e.last));
          lane_ok = 1; bad_k = -1;
          for (int k = 0; k < NL; k++) begin
            bit en_e;
            int a_e;
            en_e = k < e.h * e.w;
            a_e = en_e ? (e.row + k / e.w) * IMG_W + e.col + k % e.w : 0;
            if (lane_en[k] != en_e || int'(lane_addr[k*AW +: AW]) != a_e) begin
              if (lane_ok) bad_k = k;
              lane_ok = 0;
            end
          end
          chk(lane_ok, "R5", "first bad lane", bad_k, -1);
        end
      end
    end
  end

  task automatic push_frame(input int j, input int r, input bit tall);
    int h, w;
    h = tall ? (1 << (j + r)) : (1 << (j - 1));
    w = tall ? (1 << (j - 1)) : (1 << (j + r));
    for (int br = 0; br < IMG_H; br += h)
      for (int bc = 0; bc < IMG_W; bc += w) begin
        item_t it;
        it.row = br; it.col = bc; it.h = h; it.w = w;
        it.last = (br + h == IMG_H) && (bc + w == IMG_W);
        expq.push_back(it);
      end
  endtask

  task automatic pulse_start(input int j, input int r, input bit tall);
    @(posedge clk); #1;
    cfg_levels = JW'(j); cfg_scale = RW'(r); cfg_tall = tall; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic run_frame(input int j, input int r, input bit tall, input bit bp, input bit disturb);
    int n, cyc;
    bp_on = bp;
    push_frame(j, r, tall);
    n = expq.size();
    pulse_start(j, r, tall);
    @(negedge clk);
    // R8 launch one cycle after start
    chk(blk_valid === 1'b1 && cfg_err === 1'b0, "R8", "valid after start", int'(blk_valid), 1);
    cyc = 0;
    while (busy) begin
      cyc++;
      if (disturb && cyc == 5) begin
        // R10 mid-frame start and config change are ignored
        #1 cfg_levels = JW'(1); cfg_tall = ~tall; cfg_scale = '0; start = 1;
        @(posedge clk); #1 start = 0;
      end
      @(negedge clk);
    end
    if (!bp) chk(cyc == n, "R6", "busy cycles with ready high", cyc, n);
    chk(expq.size() == 0, "R4", "tiles left in queue", expq.size(), 0);
  endtask

  task automatic bad_start(input int j, input int r, input bit tall);
    pulse_start(j, r, tall);
    @(negedge clk);
    chk(cfg_err === 1'b1, "R9", "cfg_err after illegal start", int'(cfg_err), 1);
    repeat (3) @(negedge clk);
    chk(blk_valid === 1'b0 && busy === 1'b0, "R9", "no tile after illegal start", int'(blk_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(blk_valid === 1'b0 && busy === 1'b0 && cfg_err === 1'b0, "R1", "reset outputs",
        int'(blk_valid) + int'(busy) + int'(cfg_err), 0);
    run_frame(1, 0, 0, 0, 0);   // R2 small wide
    run_frame(2, 1, 0, 1, 0);   // R2 wide with back-pressure
    run_frame(2, 0, 1, 1, 0);   // R3 tall
    run_frame(2, 2, 1, 0, 0);   // R3 full-height tall
    bad_start(2, 2, 0);         // R9 width 16 does not divide 24
    bad_start(3, 0, 0);         // R9 too many levels
    bad_start(0, 0, 1);         // R9 zero levels
    bad_start(1, 3, 0);         // R9 scale too large
    run_frame(2, 0, 0, 1, 1);   // R10 disturbed frame, also clears R9 flag
    chk(cfg_err === 1'b0, "R9", "cfg_err cleared by legal start", int'(cfg_err), 0);
    // R10 start coincides with acceptance of the final tile
    bp_on = 0;
    push_frame(1, 1, 1);
    pulse_start(1, 1, 1);
    @(negedge clk);
    while (!(blk_valid && blk_last)) @(negedge clk);
    start = 1; cfg_levels = JW'(2); cfg_tall = 0;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(busy === 1'b0 && blk_valid === 1'b0, "R10", "start at final accept ignored", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(blk_valid === 1'b0 && expq.size() == 0, "R7", "idle after final tile", int'(blk_valid), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule